// File: doc/BRIEF.md
# IO Rail Power-Detect Latch Controller

This block sequences a bank of IO-rail power-detect cells and the pad-disable bits that go with them. Each rail owns one detect-enable bit and one pad-disable bit, both at the rail's index. When software is about to bring a rail up, the controller turns on the detect cells of the selected rails and presets their latches high. It then waits for a rail-stable indication. After that it opens the latches, closes them to capture the result, and switches every detect cell off. At the same time it re-enables the pads of those rails.

When a rail is about to go down, the controller sets the rail's pad-disable bits at once and starts no sequence. Two further commands clear or set pad-disable bits directly as a read-modify-write. An initialisation command latches the rails that are already powered and disables the pads of the rails named as unpowered. A build option makes the controller open the latches early, a fixed number of cycles after the preset, before the rail transition. The analog cells and the power-management unit are outside this block.

Top module: `io_pwrdet_ctrl`

## Requirements
- R1: Bit i of `det_en` and of `pad_dis` both belong to rail i. Rail `NO_DET_RAIL` (default 9) has no detect cell, so its `det_en` bit is 0 at all times.
- R2: A power-up command (op code 1) accepted in idle writes `det_en` = mask with the cell-less rail removed, on the cycle after acceptance. On the following cycle `latch_preset` is high for exactly one cycle.
- R3: After the preset, with the early option off, the controller holds `busy` high, holds `det_en`, and keeps `latch_pass` low until `rail_stable` is seen high.
- R4: On the edge that samples `rail_stable` high, `latch_pass` rises for one cycle. It then falls for one cycle of capture while `det_en` is still set. The next edge clears all of `det_en`, clears the command's bits in `pad_dis`, and returns `busy` to 0.
- R5: A power-down command (op code 2) sets the mask bits in `pad_dis` on the next cycle. It leaves `det_en` alone and does not raise `busy`.
- R6: Pad-enable (op code 3) clears and pad-disable (op code 4) sets the mask bits of `pad_dis` on the next cycle. All other bits keep their value.
- R7: An initialisation command (op code 0) raises `latch_pass` for one cycle and then lowers it for one cycle. On the next edge it clears `det_en` and sets the mask bits in `pad_dis`. It does not wait for `rail_stable`.
- R8: With `EARLY_PASS`=1, `latch_pass` rises `EARLY_DLY` cycles after the cycle in which the preset ended, without `rail_stable`. It stays high until the capture step.
- R9: Commands presented while `busy` is high, and op codes 5 to 7, have no effect on any output.
- R10: After reset, `det_en`, `pad_dis`, `latch_preset`, `latch_pass` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd_op | input | 3 | Op code: 0 init, 1 power-up, 2 power-down, 3 pad enable, 4 pad disable |
| cmd_mask | input | N_RAILS | Rail mask for the command |
| rail_stable | input | 1 | Rails have settled after power-up |
| busy | output | 1 | A latch sequence is in progress |
| det_en | output | N_RAILS | Detect-cell enables |
| latch_preset | output | 1 | One-cycle pulse that presets enabled latches high |
| latch_pass | output | 1 | Latch pass-through; its falling edge captures |
| pad_dis | output | N_RAILS | Pad-disable bits |

## Verification
The bench goes after the ordering of the seven latch steps. A design that opened the latch before `rail_stable` would show `latch_pass` high during the wait. One that dropped the cells before capture would show `det_en` at zero while `latch_pass` falls. A sweep of pad commands across many masks exposes a read-modify-write that disturbs other bits or swaps set and clear. The mask that includes the cell-less rail catches a detect enable driven onto a rail that has no cell. Commands sent mid-sequence and unknown op codes catch a controller that reacts to them. A second instance with the early option checks that the pass-through rises on exactly the right cycle.

// File: rtl/pwrdet_pkg.sv
package pwrdet_pkg;

    typedef enum logic [2:0] {
        OP_INIT    = 3'd0,
        OP_UP      = 3'd1,
        OP_DOWN    = 3'd2,
        OP_PAD_EN  = 3'd3,
        OP_PAD_DIS = 3'd4
    } pd_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EN,
        S_PRE,
        S_DLY,
        S_WAIT,
        S_PASS,
        S_CAP
    } pd_state_e;

    function automatic logic is_pad_op(input logic [2:0] op);
        return (op == OP_DOWN) || (op == OP_PAD_EN) || (op == OP_PAD_DIS);
    endfunction

endpackage

// File: rtl/pwrdet_seq.sv
module pwrdet_seq
    import pwrdet_pkg::*;
#(
    parameter int N        = 10,
    parameter bit EARLY_EN = 1'b0,
    parameter int DLY      = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         acc,
    input  logic [2:0]   op,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] cell_m,
    input  logic         rail_stable,
    output logic         busy,
    output logic [N-1:0] det,
    output logic         preset,
    output logic         pass,
    output logic [N-1:0] pend,
    output logic         done_set,
    output logic         done_clr
);

    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;

    pd_state_e     st;
    logic          init_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            det    <= '0;
            preset <= 1'b0;
            pass   <= 1'b0;
            pend   <= '0;
            init_q <= 1'b0;
            cnt    <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (acc && op == OP_UP) begin
                        det    <= mask & cell_m;
                        pend   <= mask;
                        init_q <= 1'b0;
                        st     <= S_EN;
                    end else if (acc && op == OP_INIT) begin
                        pass   <= 1'b1;
                        pend   <= mask;
                        init_q <= 1'b1;
                        st     <= S_PASS;
                    end
                end
                S_EN: begin
                    preset <= 1'b1;
                    st     <= S_PRE;
                end
                S_PRE: begin
                    preset <= 1'b0;
                    cnt    <= '0;
                    st     <= EARLY_EN ? S_DLY : S_WAIT;
                end
                S_DLY: begin
                    if (cnt == CW'(DLY - 1)) begin
                        pass <= 1'b1;
                        st   <= S_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_WAIT: begin
                    if (rail_stable) begin
                        pass <= 1'b1;
                        st   <= S_PASS;
                    end
                end
                S_PASS: begin
                    pass <= 1'b0;
                    st   <= S_CAP;
                end
                S_CAP: begin
                    det <= '0;
                    st  <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy     = (st != S_IDLE);
    assign done_set = (st == S_CAP) && init_q;
    assign done_clr = (st == S_CAP) && !init_q;

endmodule

// File: rtl/pwrdet_padreg.sv
module pwrdet_padreg #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_m,
    input  logic [N-1:0] clr_m,
    output logic [N-1:0] pad
);

    always_ff @(posedge clk) begin
        if (rst) pad <= '0;
        else     pad <= (pad | set_m) & ~clr_m;
    end

endmodule

// File: rtl/io_pwrdet_ctrl.sv
module io_pwrdet_ctrl
    import pwrdet_pkg::*;
#(
    parameter int N_RAILS     = 10,
    parameter int NO_DET_RAIL = 9,
    parameter bit EARLY_PASS  = 1'b0,
    parameter int EARLY_DLY   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [N_RAILS-1:0] cmd_mask,
    input  logic               rail_stable,
    output logic               busy,
    output logic [N_RAILS-1:0] det_en,
    output logic               latch_preset,
    output logic               latch_pass,
    output logic [N_RAILS-1:0] pad_dis
);

    logic [N_RAILS-1:0] cell_m;
    logic [N_RAILS-1:0] pend;
    logic [N_RAILS-1:0] set_m;
    logic [N_RAILS-1:0] clr_m;
    logic               acc;
    logic               done_set;
    logic               done_clr;

    for (genvar g = 0; g < N_RAILS; g++) begin : g_cell
        assign cell_m[g] = (g != NO_DET_RAIL);
    end

    assign acc = cmd_valid && !busy;

    pwrdet_seq #(
        .N       (N_RAILS),
        .EARLY_EN(EARLY_PASS),
        .DLY     (EARLY_DLY)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .op         (cmd_op),
        .mask       (cmd_mask),
        .cell_m     (cell_m),
        .rail_stable(rail_stable),
        .busy       (busy),
        .det        (det_en),
        .preset     (latch_preset),
        .pass       (latch_pass),
        .pend       (pend),
        .done_set   (done_set),
        .done_clr   (done_clr)
    );

    always_comb begin
        set_m = '0;
        clr_m = '0;
        if (acc && is_pad_op(cmd_op)) begin
            if (cmd_op == OP_PAD_EN) clr_m = cmd_mask;
            else                     set_m = cmd_mask;
        end
        if (done_set) set_m = pend;
        if (done_clr) clr_m = pend;
    end

    pwrdet_padreg #(.N(N_RAILS)) u_pad (
        .clk  (clk),
        .rst  (rst),
        .set_m(set_m),
        .clr_m(clr_m),
        .pad  (pad_dis)
    );

endmodule

// File: rtl/pwrdet_chk.sv
module pwrdet_chk #(
    parameter int N      = 10,
    parameter int NO_DET = 9
) (
    input logic         clk,
    input logic         rst,
    input logic         cmd_valid,
    input logic [2:0]   cmd_op,
    input logic [N-1:0] cmd_mask,
    input logic         busy,
    input logic [N-1:0] det_en,
    input logic         latch_preset,
    input logic         latch_pass,
    input logic [N-1:0] pad_dis
);

    AST_NO_CELL_DET: assert property (@(posedge clk) disable iff (rst)
        !det_en[NO_DET]); // R1

    AST_PRESET_PULSE: assert property (@(posedge clk) disable iff (rst)
        latch_preset |=> !latch_preset && busy && det_en == $past(det_en)); // R2

    AST_CAPTURE_THEN_OFF: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_pass) |=> det_en == '0 && !busy); // R4

    AST_DOWN_SETS_PADS: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !busy && cmd_op == 3'd2 |=>
            (pad_dis & $past(cmd_mask)) == $past(cmd_mask) && !busy); // R5

    AST_IDLE_PADS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy && !cmd_valid |=> $stable(pad_dis)); // R9

endmodule

bind io_pwrdet_ctrl pwrdet_chk #(.N(N_RAILS), .NO_DET(NO_DET_RAIL)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_mask    (cmd_mask),
    .busy        (busy),
    .det_en      (det_en),
    .latch_preset(latch_preset),
    .latch_pass  (latch_pass),
    .pad_dis     (pad_dis)
);

// File: tb/io_pwrdet_ctrl_tb.sv
`timescale 1ns/1ps
module io_pwrdet_ctrl_tb;

    localparam int N = 10;
    localparam int QD = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cv = 2'b00;
    logic [2:0]   op = 3'd0;
    logic [N-1:0] msk = '0;
    logic         stb = 1'b0;
    logic         busy0, pre0, pas0, busy1, pre1, pas1;
    logic [N-1:0] det0, pad0, det1, pad1;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [N-1:0] pm;

    always #2.5 clk = ~clk;

    io_pwrdet_ctrl u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cv[0]), .cmd_op(op), .cmd_mask(msk),
        .rail_stable(stb), .busy(busy0), .det_en(det0), .latch_preset(pre0),
        .latch_pass(pas0), .pad_dis(pad0)
    );

    io_pwrdet_ctrl #(.EARLY_PASS(1'b1), .EARLY_DLY(QD)) u_dut_q (
        .clk(clk), .rst(rst), .cmd_valid(cv[1]), .cmd_op(op), .cmd_mask(msk),
        .rail_stable(stb), .busy(busy1), .det_en(det1), .latch_preset(pre1),
        .latch_pass(pas1), .pad_dis(pad1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input int d, input logic [2:0] o, input logic [N-1:0] m);
        op = o;
        msk = m;
        cv[d] = 1'b1;
        tick();
        cv = 2'b00;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=1 exp=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        chk("R10 det", 32'(det0), 0);
        chk("R10 pad", 32'(pad0), 0);
        chk("R10 busy", 32'(busy0), 0);
        chk("R10 preset", 32'(pre0), 0);
        chk("R10 pass", 32'(pas0), 0);
        pm = '0;

        // R6 sweep of pad enable/disable masks
        for (int i = 0; i < 40; i++) begin
            logic [N-1:0] m;
            m = N'((i * 157 + 33) % 1024);
            if (i % 2 == 1) begin issue(0, 3'd4, m); pm = pm | m; end
            else            begin issue(0, 3'd3, m); pm = pm & ~m; end
            chk("R6 pad", 32'(pad0), 32'(pm));
            chk("R6 busy", 32'(busy0), 0);
        end

        // R5 power-down
        issue(0, 3'd2, 10'h2A5);
        pm = pm | 10'h2A5;
        chk("R5 pad", 32'(pad0), 32'(pm));
        chk("R5 det", 32'(det0), 0);
        chk("R5 busy", 32'(busy0), 0);

        // R1..R4 power-up sequences over several masks
        for (int k = 0; k < 4; k++) begin
            logic [N-1:0] m;
            m = (k == 0) ? 10'h3FF : (k == 1) ? 10'h200 : (k == 2) ? 10'h011 : 10'h1C0;
            issue(0, 3'd4, 10'h3FF);
            pm = 10'h3FF;
            issue(0, 3'd1, m);
            chk("R1 R2 det", 32'(det0), 32'(m & 10'h1FF));
            chk("R2 busy", 32'(busy0), 1);
            chk("R2 preset low", 32'(pre0), 0);
            tick();
            chk("R2 preset", 32'(pre0), 1);
            tick();
            chk("R2 preset end", 32'(pre0), 0);
            for (int w = 0; w < 4; w++) begin
                if (w == 1) begin
                    issue(0, 3'd3, 10'h3FF);
                    chk("R9 busy cmd pad", 32'(pad0), 32'(pm));
                end else begin
                    tick();
                end
                chk("R3 pass", 32'(pas0), 0);
                chk("R3 det", 32'(det0), 32'(m & 10'h1FF));
                chk("R3 busy", 32'(busy0), 1);
            end
            stb = 1'b1;
            tick();
            stb = 1'b0;
            chk("R4 pass open", 32'(pas0), 1);
            tick();
            chk("R4 pass capture", 32'(pas0), 0);
            chk("R4 det held", 32'(det0), 32'(m & 10'h1FF));
            tick();
            pm = pm & ~m;
            chk("R4 det off", 32'(det0), 0);
            chk("R4 pad", 32'(pad0), 32'(pm));
            chk("R4 busy", 32'(busy0), 0);
        end

        // R7 init
        issue(0, 3'd0, 10'h0F0);
        chk("R7 pass", 32'(pas0), 1);
        chk("R7 busy", 32'(busy0), 1);
        tick();
        chk("R7 capture", 32'(pas0), 0);
        tick();
        pm = pm | 10'h0F0;
        chk("R7 det", 32'(det0), 0);
        chk("R7 pad", 32'(pad0), 32'(pm));
        chk("R7 busy end", 32'(busy0), 0);

        // R9 unknown op codes
        for (int u = 5; u < 8; u++) begin
            issue(0, 3'(u), 10'h3FF);
            chk("R9 unknown pad", 32'(pad0), 32'(pm));
            chk("R9 unknown busy", 32'(busy0), 0);
            chk("R9 unknown pass", 32'(pas0), 0);
        end

        // R8 early pass-through on the second instance
        issue(1, 3'd1, 10'h005);
        chk("R8 det", 32'(det1), 32'h005);
        tick();
        chk("R8 preset", 32'(pre1), 1);
        tick();
        for (int j = 1; j < QD; j++) begin
            tick();
            chk("R8 pass not yet", 32'(pas1), 0);
        end
        tick();
        chk("R8 pass early", 32'(pas1), 1);
        tick();
        chk("R8 pass hold", 32'(pas1), 1);
        chk("R8 busy", 32'(busy1), 1);
        stb = 1'b1;
        tick();
        stb = 1'b0;
        chk("R8 pass open", 32'(pas1), 1);
        tick();
        chk("R8 capture", 32'(pas1), 0);
        tick();
        chk("R8 det off", 32'(det1), 0);
        chk("R8 busy end", 32'(busy1), 0);
        chk("R8 pad", 32'(pad1), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule